// File: doc/BRIEF.md
# Receive Message Queue Index Controller

This block keeps the bookkeeping for a circular receive queue whose slots sit in a shared message RAM. It holds the write (put) and read (get) slot indices and the fill level. It turns the indices into RAM word addresses: `wr_addr` is the slot where the next incoming message goes, and `rd_addr` is the oldest unread slot. The receive path pulses `store_req` each time it stores a message. The host pulses `host_ack` after it has consumed the oldest slot.

A single 32-bit configuration word sets four things: a full-queue policy, a watermark level, a slot count and a base word address. The word can be changed only while both the change-enable input and the initialization input are high. Accepting a new configuration empties the queue. The block raises three flags: full, message-lost and watermark. The host clears the lost and watermark flags with write-one-to-clear strobes.

Top module: `rxq_ctrl`

## Requirements
- R1: A configuration write takes effect only when `cfg_wr`, `cfg_chg_en` and `cfg_init` are all high in the same cycle. Any other write leaves the read-back word, the fill level and both addresses unchanged.
- R2: The read-back word is zero after reset and has this layout: bit 31 is the policy, bits 30:24 are the watermark, bits 22:16 are the slot count and bits 15:2 are the base word address. Bits 23, 1 and 0 read as zero.
- R3: A slot count above 64 acts as 64 slots. `full` rises on the 64th accepted message, not earlier. The read-back word still shows the value that was written.
- R4: With a slot count of 0, every `store_req` is dropped and sets `msg_lost`, while `fill_level` and `full` stay 0.
- R5: `full` is high exactly when `fill_level` equals the effective slot count. A `host_ack` while the queue is empty changes nothing.
- R6: With policy 0 (blocking), a `store_req` into a full queue without a simultaneous `host_ack` is dropped. It sets `msg_lost` and leaves the fill level and `wr_addr` unchanged.
- R7: With policy 1 (overwrite), a `store_req` into a full queue is accepted. The oldest slot is discarded, so both indices advance, the fill level stays the same and `msg_lost` is not set.
- R8: The indices wrap from count-1 to 0. Each address equals base + index × ELEM_WORDS and appears on `wr_addr`/`rd_addr` one cycle after the index changes.
- R9: `wm_irq` is set in the cycle the fill level rises from below the watermark to the watermark or above. A watermark of 0 or above 64 never sets it. A `clr_wm` pulse clears it.
- R10: An accepted configuration write resets both indices and the fill level to zero and clears `full`.
- R11: A `clr_lost` pulse clears `msg_lost`.
- R12: A `store_req` together with a `host_ack` on a full queue is accepted in any policy. The fill level stays the same and `msg_lost` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chg_en | input | 1 | Configuration change enable |
| cfg_init | input | 1 | Initialization state active |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| store_req | input | 1 | A message was stored at `wr_addr` |
| host_ack | input | 1 | Host has consumed the slot at `rd_addr` |
| clr_wm | input | 1 | Write-one-to-clear for `wm_irq` |
| clr_lost | input | 1 | Write-one-to-clear for `msg_lost` |
| wr_addr | output | ADDR_W | RAM word address of the next write slot |
| rd_addr | output | ADDR_W | RAM word address of the oldest slot |
| fill_level | output | FILL_W | Number of occupied slots |
| full | output | 1 | Queue full |
| msg_lost | output | 1 | Message dropped flag |
| wm_irq | output | 1 | Watermark reached flag |

## Verification
Store and acknowledge pulses are driven against several configurations: a three-slot blocking queue, a two-slot overwrite queue, a two-slot queue with a store and an acknowledge in the same cycle, an empty (zero-count) queue, and a clamped oversize queue. Comparing a store into a full queue in the blocking and overwrite configurations shows whether the get index moves and whether the lost flag is set. The store-with-acknowledge case shows that a slot freed in the same cycle is taken into account. The oversize and zero-count runs check the clamp edges of the slot count. A watermark beyond 64 checks that the watermark is disabled rather than wrapped. Locked writes are tried with each enable missing in turn, and are checked against read-back, fill level and addresses.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CFG_W    = 32;
  localparam int FIELD_W  = 7;
  localparam int BASE_W   = 14;

  typedef struct packed {
    logic               ovw;
    logic [FIELD_W-1:0] wm;
    logic [FIELD_W-1:0] cnt;
    logic [BASE_W-1:0]  base;
  } rxq_cfg_t;

  function automatic logic [CFG_W-1:0] pack_cfg(rxq_cfg_t c);
    return {c.ovw, c.wm, 1'b0, c.cnt, c.base, 2'b00};
  endfunction
endpackage

// File: rtl/rxq_cfg_reg.sv
module rxq_cfg_reg
  import rxq_pkg::*;
#(
  parameter int MAX_ELEMS = 64,
  localparam int FILL_W = $clog2(MAX_ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chg_en,
  input  logic              init,
  input  logic              wr,
  input  logic [CFG_W-1:0]  wdata,
  output rxq_cfg_t          cfg,
  output logic [CFG_W-1:0]  rdata,
  output logic              reload,
  output logic [FILL_W-1:0] eff_cnt,
  output logic [FILL_W-1:0] wm_lvl
);
  localparam logic [FIELD_W-1:0] MAX_F = FIELD_W'(MAX_ELEMS);

  assign reload = wr && chg_en && init;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (reload) begin
      cfg.ovw  <= wdata[31];
      cfg.wm   <= wdata[30:24];
      cfg.cnt  <= wdata[22:16];
      cfg.base <= wdata[15:2];
    end
  end

  assign rdata = pack_cfg(cfg);

  always_comb begin
    eff_cnt = (cfg.cnt > MAX_F) ? FILL_W'(MAX_ELEMS) : FILL_W'(cfg.cnt);
    wm_lvl  = (cfg.wm > MAX_F) ? '0 : FILL_W'(cfg.wm);
  end
endmodule

// File: rtl/rxq_index.sv
module rxq_index #(
  parameter int MAX_ELEMS = 64,
  localparam int FILL_W = $clog2(MAX_ELEMS + 1),
  localparam int IDX_W  = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic              ovw,
  input  logic [FILL_W-1:0] eff_cnt,
  input  logic [FILL_W-1:0] wm_lvl,
  input  logic              store,
  input  logic              ack,
  input  logic              clr_wm,
  input  logic              clr_lost,
  output logic [IDX_W-1:0]  put_idx,
  output logic [IDX_W-1:0]  get_idx,
  output logic [FILL_W-1:0] fill,
  output logic              full,
  output logic              lost,
  output logic              wm_irq
);
  logic              pop, push, adv_get_ovw, drop, has_q, full_now;
  logic [IDX_W-1:0]  put_n, get_n;
  logic [FILL_W-1:0] fill_n;

  function automatic logic [IDX_W-1:0] step_idx(logic [IDX_W-1:0] i,
                                                logic [FILL_W-1:0] n);
    return ((FILL_W'(i) + FILL_W'(1)) >= n) ? '0 : i + IDX_W'(1);
  endfunction

  always_comb begin
    has_q       = (eff_cnt != '0);
    full_now    = has_q && (fill == eff_cnt);
    pop         = ack && (fill != '0);
    push        = 1'b0;
    adv_get_ovw = 1'b0;
    drop        = 1'b0;
    if (store) begin
      if (!has_q)                 drop = 1'b1;
      else if (!full_now || pop)  push = 1'b1;
      else if (ovw) begin
        push        = 1'b1;
        adv_get_ovw = 1'b1;
      end else                    drop = 1'b1;
    end
    put_n  = push ? step_idx(put_idx, eff_cnt) : put_idx;
    get_n  = (pop || adv_get_ovw) ? step_idx(get_idx, eff_cnt) : get_idx;
    fill_n = fill + FILL_W'(push && !adv_get_ovw) - FILL_W'(pop);
    if (reload) begin
      put_n  = '0;
      get_n  = '0;
      fill_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      put_idx <= '0;
      get_idx <= '0;
      fill    <= '0;
      full    <= 1'b0;
      lost    <= 1'b0;
      wm_irq  <= 1'b0;
    end else begin
      put_idx <= put_n;
      get_idx <= get_n;
      fill    <= fill_n;
      full    <= has_q && !reload && (fill_n == eff_cnt);
      if (drop && !reload) lost <= 1'b1;
      else if (clr_lost)   lost <= 1'b0;
      if ((wm_lvl != '0) && (fill < wm_lvl) && (fill_n >= wm_lvl)) wm_irq <= 1'b1;
      else if (clr_wm)                                             wm_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen #(
  parameter int ADDR_W     = 16,
  parameter int BASE_W     = 14,
  parameter int IDX_W      = 6,
  parameter int ELEM_WORDS = 4,
  parameter int NPORTS     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [BASE_W-1:0]             base,
  input  logic [NPORTS-1:0][IDX_W-1:0]  idx,
  output logic [NPORTS-1:0][ADDR_W-1:0] addr
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) addr[g] <= '0;
      else     addr[g] <= ADDR_W'(base) + ADDR_W'(idx[g]) * ADDR_W'(ELEM_WORDS);
    end
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int MAX_ELEMS  = 64,
  parameter int ELEM_WORDS = 4,
  parameter int ADDR_W     = 16,
  localparam int FILL_W = $clog2(MAX_ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_chg_en,
  input  logic              cfg_init,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              store_req,
  input  logic              host_ack,
  input  logic              clr_wm,
  input  logic              clr_lost,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [FILL_W-1:0] fill_level,
  output logic              full,
  output logic              msg_lost,
  output logic              wm_irq
);
  localparam int IDX_W = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1;

  rxq_cfg_t                    cfg;
  logic                        reload;
  logic [FILL_W-1:0]           eff_cnt, wm_lvl;
  logic [IDX_W-1:0]            put_idx, get_idx;
  logic [1:0][ADDR_W-1:0]      addrs;

  rxq_cfg_reg #(.MAX_ELEMS(MAX_ELEMS)) u_cfg (
    .clk(clk), .rst(rst), .chg_en(cfg_chg_en), .init(cfg_init),
    .wr(cfg_wr), .wdata(cfg_wdata), .cfg(cfg), .rdata(cfg_rdata),
    .reload(reload), .eff_cnt(eff_cnt), .wm_lvl(wm_lvl)
  );

  rxq_index #(.MAX_ELEMS(MAX_ELEMS)) u_idx (
    .clk(clk), .rst(rst), .reload(reload), .ovw(cfg.ovw),
    .eff_cnt(eff_cnt), .wm_lvl(wm_lvl), .store(store_req), .ack(host_ack),
    .clr_wm(clr_wm), .clr_lost(clr_lost), .put_idx(put_idx),
    .get_idx(get_idx), .fill(fill_level), .full(full), .lost(msg_lost),
    .wm_irq(wm_irq)
  );

  rxq_addr_gen #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .IDX_W(IDX_W),
    .ELEM_WORDS(ELEM_WORDS), .NPORTS(2)
  ) u_addr (
    .clk(clk), .rst(rst), .base(cfg.base),
    .idx({get_idx, put_idx}), .addr(addrs)
  );

  assign wr_addr = addrs[0];
  assign rd_addr = addrs[1];
endmodule

// File: rtl/rxq_ctrl_chk.sv
module rxq_ctrl_chk #(
  parameter int MAX_ELEMS = 64,
  localparam int FILL_W = $clog2(MAX_ELEMS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_chg_en,
  input logic              cfg_init,
  input logic              cfg_wr,
  input logic [31:0]       cfg_rdata,
  input logic              store_req,
  input logic              host_ack,
  input logic [FILL_W-1:0] fill_level,
  input logic              full,
  input logic              msg_lost
);
  logic cfg_take;
  assign cfg_take = cfg_wr && cfg_chg_en && cfg_init;

  p_cfg_lock_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_take |=> $stable(cfg_rdata));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[23] == 1'b0) && (cfg_rdata[1:0] == 2'b00));

  p_fill_max_r3: assert property (@(posedge clk) disable iff (rst)
    fill_level <= FILL_W'(MAX_ELEMS));

  p_size0_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[22:16] == 7'd0) |-> (fill_level == '0) && !full);

  p_full_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    full |-> (fill_level != '0));

  p_empty_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (fill_level == '0) && host_ack && !store_req |=> (fill_level == '0));

  p_block_drop_r6: assert property (@(posedge clk) disable iff (rst)
    full && store_req && !host_ack && !cfg_take && !cfg_rdata[31]
    |=> msg_lost && $stable(fill_level));

  p_ovw_keep_r7: assert property (@(posedge clk) disable iff (rst)
    full && store_req && !host_ack && !cfg_take && cfg_rdata[31]
    |=> full && $stable(fill_level));

  p_both_keep_r12: assert property (@(posedge clk) disable iff (rst)
    full && store_req && host_ack && !cfg_take |=> full);
endmodule

bind rxq_ctrl rxq_ctrl_chk #(.MAX_ELEMS(MAX_ELEMS)) u_chk (
  .clk(clk), .rst(rst), .cfg_chg_en(cfg_chg_en), .cfg_init(cfg_init),
  .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata), .store_req(store_req),
  .host_ack(host_ack), .fill_level(fill_level), .full(full),
  .msg_lost(msg_lost)
);

// File: tb/rxq_ctrl_bench.sv
module rxq_ctrl_bench;
  localparam int ADDR_W = 16;
  localparam int FILL_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_chg_en = 0, cfg_init = 0, cfg_wr = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic store_req = 0, host_ack = 0, clr_wm = 0, clr_lost = 0;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [FILL_W-1:0] fill_level;
  logic full, msg_lost, wm_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxq_ctrl u_rxq_ctrl (
    .clk(clk), .rst(rst), .cfg_chg_en(cfg_chg_en), .cfg_init(cfg_init),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .store_req(store_req), .host_ack(host_ack), .clr_wm(clr_wm),
    .clr_lost(clr_lost), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .fill_level(fill_level), .full(full), .msg_lost(msg_lost),
    .wm_irq(wm_irq)
  );

  function automatic logic [31:0] mk(bit ovw, int wm, int cnt, int base);
    return {ovw, 7'(wm), 1'b0, 7'(cnt), 14'(base), 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit s, bit a);
    @(negedge clk);
    store_req = s; host_ack = a;
    @(negedge clk);
    store_req = 0; host_ack = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    clr_wm = 1; clr_lost = 1;
    @(negedge clk);
    clr_wm = 0; clr_lost = 0;
  endtask

  task automatic cfg_put(logic [31:0] d, bit ce, bit in);
    @(negedge clk);
    cfg_wdata = d; cfg_chg_en = ce; cfg_init = in; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_chg_en = 0; cfg_init = 0;
    step(0, 0);
  endtask

  task automatic t_reset();
    chk("R2 reset rdata", cfg_rdata, 0);
    chk("R2 reset fill", 32'(fill_level), 0);
    chk("R2 reset flags", {29'd0, full, msg_lost, wm_irq}, 0);
  endtask

  task automatic t_lock();
    cfg_put(32'hFFFF_FFFF, 1, 0);
    chk("R1 no init", cfg_rdata, 0);
    cfg_put(32'hFFFF_FFFF, 0, 1);
    chk("R1 no chg_en", cfg_rdata, 0);
    cfg_put(32'hFFFF_FFFF, 1, 1);
    chk("R2 layout", cfg_rdata, 32'hFF7F_FFFC);
  endtask

  task automatic t_size0();
    cfg_put(mk(0, 1, 0, 'h10), 1, 1);
    clr_flags();
    step(1, 0);
    chk("R4 fill", 32'(fill_level), 0);
    chk("R4 full", 32'(full), 0);
    chk("R4 lost", 32'(msg_lost), 1);
    clr_flags();
    chk("R11 lost clr", 32'(msg_lost), 0);
  endtask

  task automatic t_basic();
    cfg_put(mk(0, 2, 3, 'h100), 1, 1);
    clr_flags();
    chk("R8 wr base", 32'(wr_addr), 'h100);
    chk("R8 rd base", 32'(rd_addr), 'h100);
    step(1, 0); step(0, 0);
    chk("R5 fill1", 32'(fill_level), 1);
    chk("R8 wr+1", 32'(wr_addr), 'h104);
    chk("R9 wm low", 32'(wm_irq), 0);
    step(1, 0);
    chk("R9 wm hit", 32'(wm_irq), 1);
    step(1, 0); step(0, 0);
    chk("R5 full", {fill_level, full}, {7'd3, 1'b1});
    chk("R8 wr wrap", 32'(wr_addr), 'h100);
    step(1, 0); step(0, 0);
    chk("R6 drop fill", 32'(fill_level), 3);
    chk("R6 drop lost", 32'(msg_lost), 1);
    chk("R6 drop wr", 32'(wr_addr), 'h100);
    step(0, 1); step(0, 0);
    chk("R5 not full", {fill_level, full}, {7'd2, 1'b0});
    chk("R8 rd+1", 32'(rd_addr), 'h104);
    clr_flags();
    chk("R9 wm clr", 32'(wm_irq), 0);
    step(0, 1); step(0, 1); step(0, 1); step(0, 0);
    chk("R5 empty ack", 32'(fill_level), 0);
    chk("R8 rd wrap", 32'(rd_addr), 'h100);
  endtask

  task automatic t_both_full();
    cfg_put(mk(0, 0, 2, 0), 1, 1);
    clr_flags();
    step(1, 0); step(1, 0);
    step(1, 1); step(0, 0);
    chk("R12 fill", {fill_level, full}, {7'd2, 1'b1});
    chk("R12 lost", 32'(msg_lost), 0);
    chk("R12 wr", 32'(wr_addr), 4);
    chk("R12 rd", 32'(rd_addr), 4);
  endtask

  task automatic t_overwrite();
    cfg_put(mk(1, 0, 2, 'h20), 1, 1);
    clr_flags();
    step(1, 0); step(1, 0);
    step(1, 0); step(0, 0);
    chk("R7 fill", {fill_level, full}, {7'd2, 1'b1});
    chk("R7 lost", 32'(msg_lost), 0);
    chk("R7 wr", 32'(wr_addr), 'h24);
    chk("R7 rd", 32'(rd_addr), 'h24);
  endtask

  task automatic t_reload();
    cfg_put(mk(0, 0, 9, 'h50), 1, 0);
    chk("R1 locked fill", 32'(fill_level), 2);
    chk("R1 locked rd", 32'(rd_addr), 'h24);
    cfg_put(mk(0, 0, 5, 'h40), 1, 1);
    chk("R10 fill", {fill_level, full}, 0);
    chk("R10 wr", 32'(wr_addr), 'h40);
    chk("R10 rd", 32'(rd_addr), 'h40);
  endtask

  task automatic t_clamp();
    cfg_put(mk(0, 80, 100, 0), 1, 1);
    clr_flags();
    for (int i = 0; i < 63; i++) step(1, 0);
    chk("R3 63 not full", {fill_level, full}, {7'd63, 1'b0});
    step(1, 0); step(0, 0);
    chk("R3 64 full", {fill_level, full}, {7'd64, 1'b1});
    chk("R9 wm>64 off", 32'(wm_irq), 0);
    chk("R3 rdata raw", 32'(cfg_rdata[22:16]), 100);
    chk("R8 wr wrap64", 32'(wr_addr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step(0, 0);
    t_reset();
    t_lock();
    t_size0();
    t_basic();
    t_both_full();
    t_overwrite();
    t_reload();
    t_clamp();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule